// File: doc/BRIEF.md
# Multi-rate TDM serial input receiver

The receiver takes sixteen serial time-division-multiplexed input lines that share one input clock and one active-low frame pulse recurring every 125 us. Each line carries 8-bit channels at its own rate: 2.048, 4.096 or 8.192 Mb/s. A 3-bit clock-mode input states the clock frequency in use: 16.384, 8.192 or 4.096 MHz. The clock must run at twice the fastest rate in use. Each line therefore takes one bit every 2, 4 or 8 clock cycles, counted from the common frame boundary.

The block checks the configuration and counts time from each frame pulse. It captures every line's bits in the middle of their cells and assembles them most-significant bit first into channel bytes. Completed bytes leave through one output port, one per cycle, each tagged with its line number and channel number. A reserved clock mode, or more active channels than the 512-channel budget, raises a configuration error and stops reception. A line with a reserved rate code, or one set faster than half the clock frequency, is flagged on its own and produces no bytes.

Top module: `mrtdm_receiver`

## Requirements
- R1: `clkMode` 000, 001 and 010 select clock level 2, 1 and 0, which are 16.384, 8.192 and 4.096 MHz. Codes 011 to 111 are reserved: `configError` goes to 1 and no byte is delivered.
- R2: Line i takes its rate code from `rateSel[3i+2:3i]`. Code 000 is 2.048 Mb/s (level 0, 32 channels), 001 is 4.096 Mb/s (level 1, 64 channels) and 010 is 8.192 Mb/s (level 2, 128 channels). Codes 011 to 111 set `streamError[i]`, and that line delivers no byte.
- R3: A line whose rate level is above the clock level sets `streamError[i]` and delivers no byte.
- R4: The channel counts of all lines without `streamError` are added up. A total above 512 sets `configError`, and then no byte is delivered. A total of exactly 512 is accepted.
- R5: A line's bit cell lasts P = 2 << (clock level - rate level) cycles. The cycle after the clock edge that samples `framePulseN` low is offset 0 of bit 0 of channel 0. Each bit is taken from the cycle at offset P/2 of its cell.
- R6: Bits are assembled most-significant bit first, 8 to a byte. `byteChannel` is the byte's channel position in the frame and `byteStream` is its line number.
- R7: Each byte is shown for exactly one cycle with `byteValid`. If no lower-numbered line is waiting, the byte appears on the first clock edge after the edge that captures its last bit. With all lines at 2.048 Mb/s and clock mode 000, the first byte is valid 62 edges after the frame-pulse edge.
- R8: When several lines finish a byte on the same edge, the bytes leave on consecutive cycles, lowest line number first.
- R9: No bit is sampled before the first frame pulse. No bit is sampled after the last cycle of a frame until the next pulse arrives. A frame lasts 512 << clock level cycles.
- R10: While `rstN` is low, `byteValid`, `configError` and `streamError` are 0 whatever the configuration. The error flags follow a configuration change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkMode | input | 3 | Clock frequency selection |
| rateSel | input | 48 | Per-line rate codes, 3 bits per line |
| framePulseN | input | 1 | Frame pulse, active low, one clock wide |
| serIn | input | 16 | Serial data, one bit per line |
| byteValid | output | 1 | One-cycle strobe for a completed byte |
| byteData | output | 8 | Completed channel byte |
| byteStream | output | 4 | Line number of the byte |
| byteChannel | output | 7 | Channel number of the byte |
| configError | output | 1 | Reserved clock mode or channel budget exceeded |
| streamError | output | 16 | Per-line reserved or too-fast rate |

## Verification
Two things are hardest to reach from the ports: exact mid-cell sampling, and sixteen lines finishing a byte on the same edge. To test sampling, the stimulus drives the true bit only in the cycle at offset P/2 of each cell and drives its inverse in every other cycle, so any phase error corrupts the data. To test the burst, all sixteen lines are given the same rate so they finish together. The bench then checks the delivery order and spacing against the frame-pulse edge. Mixed-rate frames, frames over the channel budget and frames with reserved codes cover the error paths. Idle cycles after each frame show that sampling stops at the frame end.

// File: rtl/mrtdm_pkg.sv
package mrtdm_pkg;
  localparam int NUM_STREAMS    = 16;
  localparam int SEL_W          = 3;
  localparam int LVL_W          = 2;
  localparam int MAX_LVL        = 2;
  localparam int SHIFT_W        = 2;
  localparam int BYTE_W         = 8;
  localparam int BIT_W          = $clog2(BYTE_W);
  localparam int BASE_CHANNELS  = 32;
  localparam int MAX_CHAN       = BASE_CHANNELS << MAX_LVL;
  localparam int CHAN_W         = $clog2(MAX_CHAN);
  localparam int STREAM_W       = $clog2(NUM_STREAMS);
  localparam int FRAME_BASE     = 512;
  localparam int CNT_W          = $clog2(FRAME_BASE << MAX_LVL);
  localparam int CHANNEL_BUDGET = 512;

  typedef struct packed {
    logic [NUM_STREAMS-1:0]             sample;
    logic [NUM_STREAMS-1:0]             last;
    logic [NUM_STREAMS-1:0][CHAN_W-1:0] chan;
  } strobes_t;
endpackage

// File: rtl/mrtdm_cfg.sv
module mrtdm_cfg
  import mrtdm_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [SEL_W-1:0]                    clkMode,
  input  logic [NUM_STREAMS*SEL_W-1:0]        rateSel,
  output logic                                configError,
  output logic [NUM_STREAMS-1:0]              streamError,
  output logic [NUM_STREAMS-1:0]              streamActive,
  output logic [NUM_STREAMS-1:0][SHIFT_W-1:0] cellShift,
  output logic [CNT_W-1:0]                    frameEnd
);
  localparam int SUM_W = $clog2(NUM_STREAMS * MAX_CHAN + 1);
  localparam logic [SUM_W-1:0] BUDGET  = SUM_W'(CHANNEL_BUDGET);
  localparam logic [SUM_W-1:0] BASE_CH = SUM_W'(BASE_CHANNELS);
  localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(MAX_LVL);

  logic              clkOk;
  logic [LVL_W-1:0]  clkLevel;
  logic [NUM_STREAMS-1:0] errNext, actNext;
  logic [NUM_STREAMS-1:0][SHIFT_W-1:0] shiftNext;
  logic [NUM_STREAMS-1:0][SUM_W-1:0]   chanNext;
  logic [SUM_W-1:0]  chanSum;
  logic [CNT_W-1:0]  frameNext;

  assign clkOk    = (clkMode <= TOP_CODE);
  assign clkLevel = clkOk ? (LVL_W'(MAX_LVL) - clkMode[LVL_W-1:0]) : '0;

  generate
    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
      logic [SEL_W-1:0] code;
      logic             codeOk;
      logic             tooFast;
      logic [LVL_W-1:0] lvl;
      assign code         = rateSel[i*SEL_W +: SEL_W];
      assign codeOk       = (code <= TOP_CODE);
      assign lvl          = code[LVL_W-1:0];
      assign tooFast      = codeOk && clkOk && (lvl > clkLevel);
      assign errNext[i]   = !codeOk || tooFast;
      assign actNext[i]   = clkOk && codeOk && !tooFast;
      assign shiftNext[i] = actNext[i] ? SHIFT_W'(clkLevel - lvl + LVL_W'(1)) : SHIFT_W'(1);
      assign chanNext[i]  = actNext[i] ? (BASE_CH << lvl) : '0;
    end
  endgenerate

  always_comb begin
    chanSum = '0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      chanSum = chanSum + chanNext[i];
    end
  end

  assign frameNext = {CNT_W{1'b1}} >> (LVL_W'(MAX_LVL) - clkLevel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      configError  <= 1'b0;
      streamError  <= '0;
      streamActive <= '0;
      cellShift    <= '0;
      frameEnd     <= '0;
    end else begin
      configError  <= !clkOk || (chanSum > BUDGET);
      streamError  <= errNext;
      streamActive <= actNext;
      cellShift    <= shiftNext;
      frameEnd     <= frameNext;
    end
  end
endmodule

// File: rtl/mrtdm_ctrl.sv
module mrtdm_ctrl
  import mrtdm_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                framePulseN,
  input  logic                                configError,
  input  logic [NUM_STREAMS-1:0]              streamActive,
  input  logic [NUM_STREAMS-1:0][SHIFT_W-1:0] cellShift,
  input  logic [CNT_W-1:0]                    frameEnd,
  output strobes_t                            strb
);
  localparam logic [SHIFT_W:0] BIT_SH = (SHIFT_W+1)'(BIT_W);

  logic [CNT_W-1:0] frameCyc;
  logic             running;
  logic [NUM_STREAMS-1:0]             sampleV, lastV;
  logic [NUM_STREAMS-1:0][CHAN_W-1:0] chanV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCyc <= '0;
      running  <= 1'b0;
    end else if (!framePulseN) begin
      frameCyc <= '0;
      running  <= !configError;
    end else if (running) begin
      frameCyc <= frameCyc + CNT_W'(1);
      if (configError || (frameCyc == frameEnd)) running <= 1'b0;
    end
  end

  generate
    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_tap
      logic [CNT_W-1:0]   phase;
      logic [CNT_W-1:0]   mid;
      logic [BIT_W-1:0]   bitPos;
      logic [SHIFT_W:0]   chanShift;
      assign phase     = frameCyc & ~({CNT_W{1'b1}} << cellShift[i]);
      assign mid       = CNT_W'(1) << (cellShift[i] - SHIFT_W'(1));
      assign bitPos    = BIT_W'(frameCyc >> cellShift[i]);
      assign chanShift = {1'b0, cellShift[i]} + BIT_SH;
      assign sampleV[i] = running && streamActive[i] && (phase == mid);
      assign lastV[i]   = sampleV[i] && (bitPos == {BIT_W{1'b1}});
      assign chanV[i]   = CHAN_W'(frameCyc >> chanShift);
    end
  endgenerate

  assign strb.sample = sampleV;
  assign strb.last   = lastV;
  assign strb.chan   = chanV;
endmodule

// File: rtl/mrtdm_datapath.sv
module mrtdm_datapath
  import mrtdm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_STREAMS-1:0] serIn,
  input  strobes_t               strb,
  output logic                   byteValid,
  output logic [BYTE_W-1:0]      byteData,
  output logic [STREAM_W-1:0]    byteStream,
  output logic [CHAN_W-1:0]      byteChannel
);
  logic [NUM_STREAMS-1:0][BYTE_W-1:0] shiftReg, holdData;
  logic [NUM_STREAMS-1:0][CHAN_W-1:0] holdChan;
  logic [NUM_STREAMS-1:0]             pending, grant;
  logic [STREAM_W-1:0]                grantIdx;
  logic                               anyPending;

  assign anyPending = |pending;

  always_comb begin
    grantIdx = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (pending[i]) grantIdx = STREAM_W'(i);
    end
  end

  assign grant = anyPending ? (NUM_STREAMS'(1) << grantIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      holdData    <= '0;
      holdChan    <= '0;
      pending     <= '0;
      byteValid   <= 1'b0;
      byteData    <= '0;
      byteStream  <= '0;
      byteChannel <= '0;
    end else begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        if (strb.sample[i]) shiftReg[i] <= {shiftReg[i][BYTE_W-2:0], serIn[i]};
        if (strb.last[i]) begin
          holdData[i] <= {shiftReg[i][BYTE_W-2:0], serIn[i]};
          holdChan[i] <= strb.chan[i];
          pending[i]  <= 1'b1;
        end else if (grant[i]) begin
          pending[i]  <= 1'b0;
        end
      end
      byteValid <= anyPending;
      if (anyPending) begin
        byteData    <= holdData[grantIdx];
        byteStream  <= grantIdx;
        byteChannel <= holdChan[grantIdx];
      end
    end
  end
endmodule

// File: rtl/mrtdm_receiver.sv
module mrtdm_receiver
  import mrtdm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [SEL_W-1:0]             clkMode,
  input  logic [NUM_STREAMS*SEL_W-1:0] rateSel,
  input  logic                         framePulseN,
  input  logic [NUM_STREAMS-1:0]       serIn,
  output logic                         byteValid,
  output logic [BYTE_W-1:0]            byteData,
  output logic [STREAM_W-1:0]          byteStream,
  output logic [CHAN_W-1:0]            byteChannel,
  output logic                         configError,
  output logic [NUM_STREAMS-1:0]       streamError
);
  logic [NUM_STREAMS-1:0]              streamActive;
  logic [NUM_STREAMS-1:0][SHIFT_W-1:0] cellShift;
  logic [CNT_W-1:0]                    frameEnd;
  strobes_t                            strb;

  mrtdm_cfg u_cfg (
    .clk(clk), .rstN(rstN), .clkMode(clkMode), .rateSel(rateSel),
    .configError(configError), .streamError(streamError),
    .streamActive(streamActive), .cellShift(cellShift), .frameEnd(frameEnd)
  );

  mrtdm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .framePulseN(framePulseN), .configError(configError),
    .streamActive(streamActive), .cellShift(cellShift), .frameEnd(frameEnd),
    .strb(strb)
  );

  mrtdm_datapath u_dp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .strb(strb),
    .byteValid(byteValid), .byteData(byteData),
    .byteStream(byteStream), .byteChannel(byteChannel)
  );
endmodule

// File: rtl/mrtdm_checks.sv
module mrtdm_checks
  import mrtdm_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   byteValid,
  input logic [STREAM_W-1:0]    byteStream,
  input logic                   configError,
  input logic [NUM_STREAMS-1:0] streamError,
  input strobes_t               strb
);
  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> (!byteValid || (byteStream != $past(byteStream)))); // R7

  AST_LAST_TO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.last) |-> ##2 byteValid); // R7

  AST_ERR_LINE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.sample & streamError) == '0)); // R3

  AST_CFG_HALT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(configError) && configError) |-> (strb.sample == '0)); // R4
endmodule

bind mrtdm_receiver mrtdm_checks u_checks (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteStream(byteStream),
  .configError(configError), .streamError(streamError), .strb(strb)
);

// File: tb/mrtdm_receiver_test.sv
module mrtdm_receiver_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  clkMode = 3'b000;
  logic [47:0] rateSel = '0;
  logic        framePulseN = 1'b1;
  logic [15:0] serIn = '0;
  logic        byteValid;
  logic [7:0]  byteData;
  logic [3:0]  byteStream;
  logic [6:0]  byteChannel;
  logic        configError;
  logic [15:0] streamError;

  mrtdm_receiver uut (
    .clk(clk), .rstN(rstN), .clkMode(clkMode), .rateSel(rateSel),
    .framePulseN(framePulseN), .serIn(serIn), .byteValid(byteValid),
    .byteData(byteData), .byteStream(byteStream), .byteChannel(byteChannel),
    .configError(configError), .streamError(streamError)
  );

  always #4ns clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic [2:0]  mode;
    logic [47:0] rates;
    logic        cfgErr;
    logic [15:0] strErr;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{3'b000, {16{3'b000}}, 1'b0, 16'h0000},
    '{3'b000, {{12{3'b111}}, {4{3'b010}}}, 1'b0, 16'hFFF0},
    '{3'b001, {3'b111, 3'b110, 3'b101, 3'b100, 3'b011, 3'b010, {4{3'b000}}, {6{3'b001}}}, 1'b0, 16'hFC00},
    '{3'b010, {{12{3'b000}}, 3'b001, {3{3'b000}}}, 1'b0, 16'h0008},
    '{3'b000, {{8{3'b000}}, 3'b001, {7{3'b000}}}, 1'b1, 16'h0000},
    '{3'b011, {16{3'b000}}, 1'b1, 16'h0000},
    '{3'b000, {{13{3'b111}}, 3'b000, 3'b001, 3'b010}, 1'b0, 16'hFFF8},
    '{3'b001, {16{3'b000}}, 1'b0, 16'h0000}
  };

  int rxCount [16][128];
  int rxBad [16];
  int unexpected = 0;
  int curVec = 0;
  int c0 = 0;
  bit collect = 1'b0;
  int burstN = 16;
  int burstS [16];
  int burstT [16];

  function automatic int clkLvl(int v);
    return 2 - int'(VECS[v].mode);
  endfunction
  function automatic int rateOf(int v, int s);
    return int'(VECS[v].rates[3*s +: 3]);
  endfunction
  function automatic bit streamOn(int v, int s);
    return !VECS[v].cfgErr && !VECS[v].strErr[s];
  endfunction
  function automatic int cellLen(int v, int s);
    return 2 << (clkLvl(v) - rateOf(v, s));
  endfunction
  function automatic int chanCount(int v, int s);
    return 32 << rateOf(v, s);
  endfunction
  function automatic logic [7:0] pat(int v, int s, int ch);
    return 8'((s * 37 + ch * 11 + v * 5 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin : collector
    int s, ch;
    if (rstN && byteValid) begin
      s  = int'(byteStream);
      ch = int'(byteChannel);
      if (!collect || !streamOn(curVec, s) || ch >= chanCount(curVec, s)) begin
        unexpected++;
      end else begin
        rxCount[s][ch]++;
        if (byteData != pat(curVec, s, ch)) rxBad[s]++;
      end
      if (burstN < 16) begin
        burstS[burstN] = s;
        burstT[burstN] = cyc - c0;
        burstN++;
      end
    end
  end

  task automatic clearBoard();
    for (int s = 0; s < 16; s++) begin
      rxBad[s] = 0;
      for (int ch = 0; ch < 128; ch++) rxCount[s][ch] = 0;
    end
    unexpected = 0;
  endtask

  task automatic runFrame(input int v);
    int frameLen;
    int P, ph, bi, ch, b;
    logic [7:0] d;
    frameLen = (VECS[v].mode <= 3'b010) ? (512 << clkLvl(v)) : 512;
    @(negedge clk) framePulseN = 1'b0;
    @(negedge clk) framePulseN = 1'b1;
    c0 = cyc;
    for (int k = 0; k < frameLen; k++) begin
      for (int s = 0; s < 16; s++) begin
        if (streamOn(v, s)) begin
          P  = cellLen(v, s);
          ph = k % P;
          bi = k / P;
          ch = bi / 8;
          b  = bi % 8;
          d  = pat(v, s, ch);
          serIn[s] = d[7-b] ^ (ph != P / 2);
        end else begin
          serIn[s] = ((k + s) % 3) == 0;
        end
      end
      @(negedge clk);
    end
    for (int k = 0; k < 40; k++) begin
      serIn = ~serIn;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #1200us;
    checks++;
    failures++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    bit ok;
    // Reset with a reserved clock mode and reserved rate codes applied
    clkMode = 3'b011;
    rateSel = '1;
    repeat (3) @(negedge clk);
    chk(byteValid == 1'b0, "R10 byteValid in reset", byteValid, 0);
    chk(configError == 1'b0, "R10 configError in reset", configError, 0);
    chk(streamError == 16'h0000, "R10 streamError in reset", streamError, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(configError == 1'b1, "R1 reserved clock mode", configError, 1);
    chk(streamError == 16'hFFFF, "R2 reserved rate codes", streamError, 16'hFFFF);

    // No sampling before the first frame pulse
    clkMode = VECS[0].mode;
    rateSel = VECS[0].rates;
    clearBoard();
    for (int k = 0; k < 100; k++) begin
      serIn = ~serIn;
      @(negedge clk);
    end
    chk(unexpected == 0, "R9 bytes before first pulse", unexpected, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      clkMode = VECS[v].mode;
      rateSel = VECS[v].rates;
      repeat (3) @(negedge clk);
      chk(configError == VECS[v].cfgErr,
          (VECS[v].mode > 3'b010) ? "R1 configError" : "R4 configError",
          configError, VECS[v].cfgErr);
      chk(streamError == VECS[v].strErr, "R2 R3 streamError", streamError, VECS[v].strErr);
      clearBoard();
      curVec = v;
      collect = 1'b1;
      if (v == 0) burstN = 0;
      runFrame(v);
      collect = 1'b0;
      for (int s = 0; s < 16; s++) begin
        if (streamOn(v, s)) begin
          ok = (rxBad[s] == 0);
          for (int ch = 0; ch < chanCount(v, s); ch++) begin
            if (rxCount[s][ch] != 1) ok = 1'b0;
          end
          chk(ok, $sformatf("R5 R6 vector %0d line %0d bytes", v, s), rxBad[s], 0);
        end
      end
      chk(unexpected == 0, $sformatf("R9 R3 R4 vector %0d stray bytes", v), unexpected, 0);
      if (v == 0) begin
        chk(burstT[0] == 62, "R7 first byte latency", burstT[0], 62);
        ok = 1'b1;
        for (int j = 0; j < 16; j++) begin
          if (burstS[j] != j || burstT[j] != 62 + j) ok = 1'b0;
        end
        chk(ok, "R8 burst order lowest line first", burstS[15], 15);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule